// File: doc/BRIEF.md
# Add-Subtract Quadrature Detector

This block recovers the in-phase and quadrature components of one or more carriers from a stream of integrating converter samples. Each sample is already a time integral over its own sampling interval, so the converter itself acts as a low-pass filter. The samples arrive at exactly four times the rate of the highest carrier. The block uses no multipliers and no reference waveform tables. Every sample is either added to or subtracted from a running sum, or left out, according to a sign that depends only on where the sample falls inside the carrier period.

In single-carrier mode, each group of four consecutive samples s0..s3 adds (s0 - s2) to I and (s1 - s3) to Q. In multi-carrier mode, several carriers run at the same time. Carrier k has a frequency of 1/2^k of the highest carrier. Its four quadrants each last 2^k samples, and its quarter-period-shifted pattern gives its quadrature reference. The sums run over a programmable number of periods. At the end of that count they are presented with a one-cycle strobe and then restart from zero. A sync input realigns the sample counter with the carrier.

Top module: `iq_sum_detector`

## Requirements
- R1: After reset, `out_vld` is 0 and every `i_out` and `q_out` lane is 0.
- R2: With `multi` = 0, the window is 4*L accepted samples, where L = `nper` (L = 1 when `nper` is 0). Number the samples from the last sync as j = 0,1,2,... Lane 0 gives I as the sum of samples with j mod 4 = 0 minus the sum of samples with j mod 4 = 2. It gives Q as the sum of samples with j mod 4 = 1 minus the sum of samples with j mod 4 = 3.
- R3: With `multi` = 1, the window is L*2^(NCAR+1) accepted samples. For lane k, the quadrant of sample j is floor(j/2^k) mod 4. I adds quadrant 0 and subtracts quadrant 2. Q adds quadrant 1 and subtracts quadrant 3.
- R4: `out_vld` is high for exactly one cycle: the cycle after the clock edge that accepts the last sample of a window. The lane outputs change only at that edge and hold their values until the next strobe.
- R5: The sums restart from zero after every window, so each window's result depends only on its own samples.
- R6: A cycle with `sync` high sets the sample index and the period count to zero and discards any partial sums. A sample presented in that same cycle is dropped.
- R7: A cycle with `smp_vld` low and `sync` low does not advance the sample index and does not change any sum.
- R8: An `nper` value of 0 behaves as a window of one period.
- R9: Lane results are AW = DW+NCAR+NW bits wide, two's complement. Full-scale inputs of opposite polarity held for `nper` = MAXN periods in either mode give the exact sum, with no wrap.
- R10: With `multi` = 0, lanes 1 and above report 0 at every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Restart sample index, period count and sums |
| multi | input | 1 | 1 = all NCAR carriers, 0 = lane 0 only |
| nper | input | NW | Window length in periods of the slowest active carrier |
| smp_vld | input | 1 | Sample strobe |
| smp | input | DW | Signed integrated sample |
| out_vld | output | 1 | One-cycle result strobe |
| i_out | output | NCAR*AW | In-phase sums; lane k in bits [k*AW +: AW] |
| q_out | output | NCAR*AW | Quadrature sums; lane k in bits [k*AW +: AW] |

## Verification
The bench builds the block with DW = 8, NCAR = 3 and MAXN = 15. That gives three lanes, a 16-sample slowest period and 15-bit results. With these values a full multi-carrier window at the largest length is only 240 samples, so the overflow corner of R9 can be reached directly with full-scale values. The values also let many random windows, with random gaps in the strobe and random sync points, run in a short run. Three lanes are enough to show that each lane's quadrant width doubles, and that lanes above 0 stay at zero in single mode.

// File: rtl/qd_pkg.sv
package qd_pkg;

  typedef enum logic [1:0] {
    SG_ZERO = 2'd0,
    SG_POS  = 2'd1,
    SG_NEG  = 2'd2
  } sign_e;

  // arm = 0 : in-phase reference, arm = 1 : quarter-period shifted reference
  function automatic sign_e ref_sign(input logic [1:0] quad, input logic arm);
    sign_e s;
    s = SG_ZERO;
    if (!arm) begin
      if (quad == 2'd0) s = SG_POS;
      else if (quad == 2'd2) s = SG_NEG;
    end else begin
      if (quad == 2'd1) s = SG_POS;
      else if (quad == 2'd3) s = SG_NEG;
    end
    return s;
  endfunction

endpackage

// File: rtl/qd_phase_ctl.sv
module qd_phase_ctl #(
  parameter int NCAR = 3,
  parameter int NW   = 4,
  localparam int PW  = NCAR + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic          multi,
  input  logic [NW-1:0] nper,
  input  logic          smp_vld,
  output logic [PW-1:0] phase,
  output logic          acc_en,
  output logic          dump
);

  logic [PW-1:0] phase_nxt;
  logic [NW-1:0] pcnt, pcnt_nxt, len_m1;
  logic          period_end;

  always_comb begin
    acc_en     = smp_vld & ~sync;
    period_end = multi ? (&phase) : (&phase[1:0]);
    len_m1     = (nper == '0) ? '0 : nper - {{(NW-1){1'b0}}, 1'b1};
    dump       = acc_en & period_end & (pcnt == len_m1);

    phase_nxt = phase;
    pcnt_nxt  = pcnt;
    if (sync) begin
      phase_nxt = '0;
      pcnt_nxt  = '0;
    end else if (acc_en) begin
      phase_nxt = phase + {{(PW-1){1'b0}}, 1'b1};
      if (period_end) begin
        pcnt_nxt = dump ? '0 : pcnt + {{(NW-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pcnt  <= '0;
    end else begin
      phase <= phase_nxt;
      pcnt  <= pcnt_nxt;
    end
  end

  a_r6_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (phase == '0) && (pcnt == '0));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !sync) |=> $stable(phase) && $stable(pcnt));

  a_r2_dump_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    dump |-> (smp_vld && !sync));

endmodule

// File: rtl/qd_carrier_acc.sv
module qd_carrier_acc
  import qd_pkg::*;
#(
  parameter int K  = 0,
  parameter int DW = 8,
  parameter int AW = 15,
  parameter int PW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 acc_en,
  input  logic                 lane_en,
  input  logic                 dump,
  input  logic [PW-1:0]        phase,
  input  logic signed [DW-1:0] smp,
  output logic signed [AW-1:0] i_res,
  output logic signed [AW-1:0] q_res
);

  logic [1:0]           quad;
  sign_e                sg_i, sg_q;
  logic signed [AW-1:0] xs, t_i, t_q;
  logic signed [AW-1:0] acc_i, acc_q, sum_i, sum_q;
  logic signed [AW-1:0] acc_i_nxt, acc_q_nxt, res_i_nxt, res_q_nxt;

  always_comb begin
    quad = phase[K+1:K];
    sg_i = ref_sign(quad, 1'b0);
    sg_q = ref_sign(quad, 1'b1);
    xs   = {{(AW-DW){smp[DW-1]}}, smp};

    unique case (sg_i)
      SG_POS:  t_i = xs;
      SG_NEG:  t_i = -xs;
      default: t_i = '0;
    endcase
    unique case (sg_q)
      SG_POS:  t_q = xs;
      SG_NEG:  t_q = -xs;
      default: t_q = '0;
    endcase
    if (!lane_en) begin
      t_i = '0;
      t_q = '0;
    end

    sum_i = acc_i + t_i;
    sum_q = acc_q + t_q;

    acc_i_nxt = acc_i;
    acc_q_nxt = acc_q;
    res_i_nxt = i_res;
    res_q_nxt = q_res;
    if (clr) begin
      acc_i_nxt = '0;
      acc_q_nxt = '0;
    end else if (acc_en) begin
      if (dump) begin
        acc_i_nxt = '0;
        acc_q_nxt = '0;
        res_i_nxt = sum_i;
        res_q_nxt = sum_q;
      end else begin
        acc_i_nxt = sum_i;
        acc_q_nxt = sum_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_i <= '0;
      acc_q <= '0;
      i_res <= '0;
      q_res <= '0;
    end else begin
      acc_i <= acc_i_nxt;
      acc_q <= acc_q_nxt;
      i_res <= res_i_nxt;
      q_res <= res_q_nxt;
    end
  end

  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> $stable(i_res) && $stable(q_res));

  a_r5_clear_after_dump: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (acc_i == '0) && (acc_q == '0));

endmodule

// File: rtl/iq_sum_detector.sv
module iq_sum_detector #(
  parameter int DW   = 8,
  parameter int NCAR = 3,
  parameter int MAXN = 15,
  localparam int NW  = $clog2(MAXN + 1),
  localparam int AW  = DW + NCAR + NW,
  localparam int PW  = NCAR + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic                 multi,
  input  logic [NW-1:0]        nper,
  input  logic                 smp_vld,
  input  logic [DW-1:0]        smp,
  output logic                 out_vld,
  output logic [NCAR*AW-1:0]   i_out,
  output logic [NCAR*AW-1:0]   q_out
);

  logic [PW-1:0] phase;
  logic          acc_en;
  logic          dump;

  qd_phase_ctl #(.NCAR(NCAR), .NW(NW)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync   (sync),
    .multi  (multi),
    .nper   (nper),
    .smp_vld(smp_vld),
    .phase  (phase),
    .acc_en (acc_en),
    .dump   (dump)
  );

  for (genvar k = 0; k < NCAR; k++) begin : g_lane
    logic                 lane_en;
    logic signed [AW-1:0] i_res, q_res;

    if (k == 0) begin : g_base
      assign lane_en = 1'b1;
    end else begin : g_upper
      assign lane_en = multi;
    end

    qd_carrier_acc #(.K(k), .DW(DW), .AW(AW), .PW(PW)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sync),
      .acc_en (acc_en),
      .lane_en(lane_en),
      .dump   (dump),
      .phase  (phase),
      .smp    (smp),
      .i_res  (i_res),
      .q_res  (q_res)
    );

    assign i_out[k*AW +: AW] = i_res;
    assign q_out[k*AW +: AW] = q_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= dump;
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

endmodule

// File: tb/sim_iq_sum_detector.sv
module sim_iq_sum_detector;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int NCAR  = 3;
  localparam int MAXN  = 15;
  localparam int NW    = $clog2(MAXN + 1);
  localparam int AW    = DW + NCAR + NW;
  localparam int SLOW  = 4 << (NCAR - 1);

  logic clk, rst_n, sync, multi, smp_vld, out_vld;
  logic [NW-1:0] nper;
  logic [DW-1:0] smp;
  logic [NCAR*AW-1:0] i_out, q_out;

  int tests = 0, fails = 0;
  bit done = 0;

  int    j_m, pc_m;
  longint acc_i[NCAR], acc_q[NCAR], hold_i[NCAR], hold_q[NCAR];

  iq_sum_detector #(.DW(DW), .NCAR(NCAR), .MAXN(MAXN)) u0 (
    .clk(clk), .rst_n(rst_n), .sync(sync), .multi(multi), .nper(nper),
    .smp_vld(smp_vld), .smp(smp), .out_vld(out_vld), .i_out(i_out), .q_out(q_out)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  function automatic longint lane_val(input logic [NCAR*AW-1:0] bus, input int k);
    logic signed [AW-1:0] v;
    v = bus[k*AW +: AW];
    return longint'(v);
  endfunction

  function automatic int sgn(input int quad, input bit arm);
    if (!arm) return (quad == 0) ? 1 : (quad == 2) ? -1 : 0;
    return (quad == 1) ? 1 : (quad == 3) ? -1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    j_m = 0; pc_m = 0;
    for (int k = 0; k < NCAR; k++) begin acc_i[k] = 0; acc_q[k] = 0; end
  endtask

  task automatic step(input bit v, input int d, input bit s);
    bit fire;
    bit pend;
    int len;
    string rq;
    @(negedge clk);
    smp_vld = v; smp = DW'(d); sync = s;
    @(posedge clk);
    #1;
    fire = 0;
    if (s) model_clear();
    else if (v) begin
      for (int k = 0; k < NCAR; k++) begin
        int quad;
        quad = (j_m >> k) & 3;
        if (multi || k == 0) begin
          acc_i[k] += sgn(quad, 0) * d;
          acc_q[k] += sgn(quad, 1) * d;
        end
      end
      pend = multi ? (j_m == SLOW - 1) : ((j_m % 4) == 3);
      j_m = (j_m + 1) % SLOW;
      len = (nper == 0) ? 1 : int'(nper);
      if (pend) begin
        pc_m++;
        if (pc_m == len) begin
          fire = 1; pc_m = 0;
          for (int k = 0; k < NCAR; k++) begin
            hold_i[k] = acc_i[k]; hold_q[k] = acc_q[k];
            acc_i[k] = 0; acc_q[k] = 0;
          end
        end
      end
    end
    chk(out_vld == fire, "R4 strobe", longint'(out_vld), longint'(fire));
    for (int k = 0; k < NCAR; k++) begin
      if (!fire) rq = "R4 hold";
      else if (!multi && k > 0) rq = "R10 idle lane";
      else if (multi) rq = "R3 multi lane";
      else rq = "R2 single lane";
      chk(lane_val(i_out, k) == hold_i[k], {rq, " I"}, lane_val(i_out, k), hold_i[k]);
      chk(lane_val(q_out, k) == hold_q[k], {rq, " Q"}, lane_val(q_out, k), hold_q[k]);
    end
  endtask

  task automatic cfg(input bit m, input int n);
    @(negedge clk);
    multi = m; nper = NW'(n);
    step(0, 0, 1);
  endtask

  task automatic run_window_rand(input int gap_pct);
    int len, need;
    len  = (nper == 0) ? 1 : int'(nper);
    need = len * (multi ? SLOW : 4);
    for (int i = 0; i < need; i++) begin
      while ($urandom_range(99, 0) < gap_pct) step(0, $urandom_range(255, 0), 0);
      step(1, int'($signed(DW'($urandom_range(255, 0)))), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; sync = 0; multi = 0; nper = '0; smp_vld = 0; smp = '0;
    for (int k = 0; k < NCAR; k++) begin hold_i[k] = 0; hold_q[k] = 0; end
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(out_vld == 0, "R1 strobe", longint'(out_vld), 0);
    for (int k = 0; k < NCAR; k++) begin
      chk(lane_val(i_out, k) == 0, "R1 I", lane_val(i_out, k), 0);
      chk(lane_val(q_out, k) == 0, "R1 Q", lane_val(q_out, k), 0);
    end
    @(negedge clk); rst_n = 1;

    // R2 directed: I = 10-30, Q = 20-40
    cfg(0, 1);
    step(1, 10, 0); step(1, 20, 0); step(1, 30, 0); step(1, 40, 0);
    chk(hold_i[0] == -20 && hold_q[0] == -20, "R2 directed model", hold_i[0], -20);
    // R4 hold across idle cycles, R7 gaps ignored
    repeat (3) step(0, 99, 0);
    // R8 nper = 0 gives one period
    cfg(0, 0);
    step(1, 5, 0); step(1, -3, 0); step(1, 1, 0); step(1, 7, 0);
    // R5 back-to-back windows
    step(1, 1, 0); step(1, 2, 0); step(1, 3, 0); step(1, 4, 0);
    // R6 sync mid-window with a dropped sample
    cfg(0, 2);
    step(1, 50, 0); step(1, 60, 0); step(1, 77, 1);
    run_window_rand(20);
    // R3 multi directed and random
    cfg(1, 1);
    for (int i = 0; i < SLOW; i++) step(1, i + 1, 0);
    cfg(1, 2);
    run_window_rand(25);
    // R9 full-scale extremes, both modes
    cfg(0, MAXN);
    for (int i = 0; i < 4 * MAXN; i++)
      step(1, (i % 4 == 0) ? -128 : (i % 4 == 2) ? 127 : (i % 4 == 1) ? 127 : -128, 0);
    chk(hold_i[0] == -longint'(MAXN) * 255, "R9 single extreme", hold_i[0], -longint'(MAXN) * 255);
    cfg(1, MAXN);
    for (int i = 0; i < SLOW * MAXN; i++)
      step(1, (((i >> (NCAR - 1)) & 3) == 0) ? -128 : (((i >> (NCAR - 1)) & 3) == 2) ? 127 : 0, 0);
    // random mix
    for (int w = 0; w < 40; w++) begin
      cfg($urandom_range(1, 0), $urandom_range(MAXN, 0));
      run_window_rand($urandom_range(40, 0));
      if ($urandom_range(3, 0) == 0) begin
        step(1, 9, 0);
        step(0, 0, 1);
      end
    end
    repeat (4) step(0, 0, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule